// File: doc/BRIEF.md
# Iterative Odd-Sum Squarer

This unit squares an unsigned operand without any multiplier. It relies on the identity k² = (k−1)² + (2k−1). Each clock cycle it adds the next odd number (1, 3, 5, …) to a running sum. The only hardware is a down-counter, one odd-term register that grows by two, an accumulator with its adder, and the muxes that load or hold them. For an operand of n, the square is ready after n iteration cycles.

A client presents the operand together with a one-cycle start strobe while the unit is idle. The unit raises busy while it iterates. When it finishes, it pulses done for one cycle and presents the 2N-bit result. The result stays unchanged until the next computation completes. A zero operand skips iteration and completes in a single cycle.

Top module: `odd_sum_squarer`

## Requirements
- R1: While reset is active (rstN low) and on the first cycle after release, busy and done are 0 and result is all zeros.
- R2: A start seen at a clock edge while busy is 0 and the operand is nonzero latches the operand, and busy is 1 after that edge.
- R3: After a computation, result equals operand × operand as a 2·WIDTH-bit unsigned value. This holds for every operand from 0 to 2^WIDTH−1, with no wrap at the maximum.
- R4: For a nonzero operand n accepted at edge E0, done is 1 right after edge E0+n, and busy is 1 for exactly the n cycles before that.
- R5: For a zero operand accepted while idle, done is 1 and result is 0 right after the accepting edge, and busy stays 0.
- R6: done is high for exactly one cycle per accepted start and is never high together with busy.
- R7: result changes only on the edge that raises done. It holds its value while the unit is idle and during the next computation.
- R8: A start that arrives while busy is 1 is ignored. The running computation keeps its operand and timing, and no extra done pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, sampled when idle |
| operand | input | WIDTH | Unsigned value to square |
| busy | output | 1 | High while iterating |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2*WIDTH | Square of the last accepted operand |

## Verification
The in-RTL assertions check on every cycle the following:
- each step raises the odd term by exactly two;
- the accumulator never wraps and the counter decrements;
- done is a single pulse that is never high together with busy;
- result moves only on completion;
- zero operands finish at once.

Only the bench scenarios can show that the final value is the true square for every operand and that the done pulse lands exactly n cycles after start. The same scenarios show that starts issued mid-computation leave the operand, the timing and the pulse count untouched.

// File: rtl/sqr_pkg.sv
package sqr_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sqrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // latch operand, clear sum, odd term to 1
    logic step;        // add odd term, advance odd term and counter
    logic finish;      // capture final sum into result
    logic zeroFinish;  // capture zero into result without iterating
  } sqrStrobe_t;

endpackage

// File: rtl/sqr_ctrl.sv
module sqr_ctrl
  import sqr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       opIsZero,
  input  logic       lastIter,
  output sqrStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  sqrState_e stateQ, stateD;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          if (opIsZero) begin
            strobe.zeroFinish = 1'b1;
          end else begin
            strobe.load = 1'b1;
            stateD      = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (lastIter) begin
          strobe.finish = 1'b1;
          stateD        = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= strobe.finish | strobe.zeroFinish;
    end
  end

  assign busy = (stateQ == ST_RUN);

  // R6: completion pulse lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: never done while iterating
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: a start during a non-final iteration keeps the unit running, no pulse
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !lastIter) |=> (busy && !done));

endmodule

// File: rtl/sqr_datapath.sv
module sqr_datapath
  import sqr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WIDTH-1:0]   operand,
  input  sqrStrobe_t         strobe,
  output logic               opIsZero,
  output logic               lastIter,
  output logic [2*WIDTH-1:0] result
);

  localparam int ACC_W = 2 * WIDTH;
  localparam int ODD_W = WIDTH + 1;   // largest odd term after last step is 2n+1

  logic [WIDTH-1:0] countQ;
  logic [ODD_W-1:0] oddQ;
  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] sumNext;
  logic [ACC_W-1:0] resultQ;

  assign sumNext  = accQ + ACC_W'(oddQ);
  assign opIsZero = (operand == '0);
  assign lastIter = (countQ == WIDTH'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      oddQ   <= ODD_W'(1);
      accQ   <= '0;
    end else if (strobe.load) begin
      countQ <= operand;
      oddQ   <= ODD_W'(1);
      accQ   <= '0;
    end else if (strobe.step) begin
      countQ <= countQ - WIDTH'(1);
      oddQ   <= oddQ + ODD_W'(2);
      accQ   <= sumNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (strobe.zeroFinish) begin
      resultQ <= '0;
    end else if (strobe.finish) begin
      resultQ <= sumNext;
    end
  end

  assign result = resultQ;

  // R3: each iteration moves to the next odd number
  a_r3_odd_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (oddQ == $past(oddQ) + ODD_W'(2)));

  // R3: accumulator never wraps
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (sumNext > accQ));

  // R4: one iteration per cycle, never stepping past zero
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (countQ != '0));

  // R7: result only moves on completion
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.finish || strobe.zeroFinish) |=> $stable(resultQ));

endmodule

// File: rtl/odd_sum_squarer.sv
module odd_sum_squarer
  import sqr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   operand,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] result
);

  sqrStrobe_t strobe;
  logic       opIsZero;
  logic       lastIter;

  sqr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opIsZero (opIsZero),
    .lastIter (lastIter),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  sqr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .operand  (operand),
    .strobe   (strobe),
    .opIsZero (opIsZero),
    .lastIter (lastIter),
    .result   (result)
  );

  // R2: nonzero start while idle raises busy
  a_r2_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && operand != '0) |=> busy);

  // R5: zero operand completes at once with zero
  a_r5_zero_fast: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && operand == '0) |=> (done && !busy && result == '0));

  // R7: any change of result coincides with done
  a_r7_change_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);

endmodule

// File: tb/odd_sum_squarer_test.sv
module odd_sum_squarer_test;

  localparam int WIDTH = 8;
  localparam int MAXOP = (1 << WIDTH) - 1;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [WIDTH-1:0]   operand = '0;
  logic               busy;
  logic               done;
  logic [2*WIDTH-1:0] result;

  odd_sum_squarer #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rstN(rstN), .start(start), .operand(operand),
    .busy(busy), .done(done), .result(result)
  );

  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    int     op;
    longint expSq;
    int     dueCyc;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    total = 0;
  int    bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pop expected item whenever done is seen
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(result == it.expSq[2*WIDTH-1:0], "R3 square", result, it.expSq);
        check(cyc == it.dueCyc, "R4 latency", cyc, it.dueCyc);
        check(!busy, "R6 done with busy", busy, 0);
      end
    end
  end

  // driver: push expectation, issue start, optionally poke start while busy
  task automatic runOp(input int op, input bit poke);
    item_t it;
    @(negedge clk);
    it.op = op;
    it.expSq = longint'(op) * longint'(op);
    it.dueCyc = cyc + 1 + op;
    sbq.push_back(it);
    start = 1'b1;
    operand = WIDTH'(op);
    @(negedge clk);
    start = 1'b0;
    if (op != 0) check(busy == 1'b1, "R2 busy after start", busy, 1);
    else begin
      check(busy == 1'b0, "R5 busy stays low", busy, 0);
      check(done == 1'b1, "R5 done at once", done, 1);
    end
    if (poke && op > 2) begin
      start = 1'b1;
      operand = WIDTH'(op - 1);
      @(negedge clk);
      start = 1'b0;
      operand = '0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R6 single pulse", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(result == '0, "R1 result in reset", result, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && result == '0, "R1 after release", result, 0);

    runOp(0, 1'b0);
    runOp(1, 1'b0);
    runOp(MAXOP, 1'b0);
    runOp(MAXOP, 1'b1);   // R8 poke during maximum
    runOp(0, 1'b0);       // R5 after a large result

    // every operand, poking every fifth one (R3, R8)
    for (int k = 0; k <= MAXOP; k++) runOp(k, (k % 5) == 3);

    // R7: result holds while idle
    runOp(13, 1'b0);
    repeat (6) @(negedge clk);
    check(result == 169, "R7 hold idle", result, 169);

    // R7: result holds during the next computation
    @(negedge clk);
    start = 1'b1; operand = 8'd20;
    begin
      item_t it;
      it.op = 20; it.expSq = 400; it.dueCyc = cyc + 21;
      sbq.push_back(it);
    end
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check(result == 169, "R7 hold while busy", result, 169);
    while (!done) @(negedge clk);
    @(negedge clk);

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R8 missing done", sbq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule